// File: doc/BRIEF.md
# Tunable-Precision Floating-Point Rounder

This block narrows an IEEE binary32 operand into a smaller floating-point format whose shape is chosen at run time. The caller supplies the significand width (hidden bit counted, 3 to 24 bits), the exponent width (5 to 8 bits), the exponent bias and one of four rounding modes. One clock edge later the block presents the packed, right-aligned result and three exception flags. The caller changes these settings per operand, so one datapath can serve several precisions.

The unbiased input exponent is moved to the programmed bias. The fraction is rounded to the kept width, and a carry out of the significand bumps the exponent. Results outside the normal range either saturate or become infinity, depending on the mode, or are flushed to a signed zero. Infinities and NaNs pass through as the reduced format's specials. A programmable bias lets a user move range toward small magnitudes for extra headroom near zero.

Top module: `tfp_rounder`

## Requirements
- R1: The outputs are registered. A result and its flags appear on the clock edge after the inputs were applied. A synchronous active-high reset drives the result word and every flag to zero.
- R2: With significand width 24, exponent width 8 and bias 127, every normal, zero or infinite input comes out bit for bit unchanged. Widths 11/5 with bias 15 give the half-precision encoding, and widths 8/8 with bias 127 give the 16-bit brain-float encoding.
- R3: For widths m and e, the packed word places the sign at bit m-1+e, the exponent in the e bits below it and the fraction in the low m-1 bits. Every bit above the sign is zero.
- R4: Mode 0 (truncate) drops every fraction bit below the kept m-1 bits.
- R5: Mode 1 (nearest, half up) increments the kept significand when the discarded part is at least one half ulp.
- R6: Mode 2 (nearest, ties to even) increments when the discarded part is above one half ulp, or exactly one half with an odd kept last bit.
- R7: Mode 3 (round to odd) truncates and then sets the kept last bit to 1 whenever any discarded bit was nonzero.
- R8: A rounding carry out of the significand adds one to the exponent and leaves a zero fraction.
- R9: The output exponent field equals the input's unbiased exponent plus the programmed bias, plus any rounding carry.
- R10: A result exponent above 2^e-2 raises overflow and inexact (flag bits ovf, inx). Modes 1 and 2 then give a signed infinity (exponent all ones, zero fraction). Modes 0 and 3 give the signed largest finite value (exponent 2^e-2, all-ones fraction).
- R11: A result exponent below 1 becomes a signed zero with underflow and inexact raised. Binary32 zeros and subnormals become a signed zero with no flag.
- R12: A NaN input gives a quiet NaN: sign kept, exponent all ones, only the top fraction bit set, no flag. An infinity keeps its sign and raises no flag.
- R13: For an in-range result, inexact is raised exactly when some discarded bit was nonzero. An exact value is not disturbed by round-to-odd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 32 | Binary32 operand |
| sig_w_i | input | 5 | Significand width m, hidden bit included (3..24) |
| exp_w_i | input | 4 | Exponent width e (5..8) |
| bias_i | input | 8 | Exponent bias of the output format |
| mode_i | input | 2 | Rounding mode: 0 truncate, 1 half up, 2 ties to even, 3 to odd |
| res_o | output | 32 | Packed result, right-aligned |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |

## Verification
The bench keeps the default source format, an 8-bit exponent with a 23-bit fraction. Every output shape therefore comes from the run-time width and bias inputs and not from parameters. It steps those inputs across the full 24/8 shape, the half-precision and 16-bit brain-float shapes, a 3-bit significand, a 6-bit exponent and a shifted bias. This reaches exact ties with both parities of the kept last bit, a rounding carry that lands exactly on overflow, the smallest normal exponent, and underflow that a larger bias turns into a representable value.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  typedef enum logic [1:0] {
    RM_TRUNC     = 2'd0,
    RM_HALF_UP   = 2'd1,
    RM_HALF_EVEN = 2'd2,
    RM_ODD       = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_NORM = 2'd1,
    CL_INF  = 2'd2,
    CL_NAN  = 2'd3
  } fclass_e;
endpackage

// File: rtl/tfp_unpack.sv
module tfp_unpack
  import tfp_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0]        operand,
  output logic                  sign,
  output fclass_e               cls,
  output logic signed [EW+1:0]  unb_exp,
  output logic [FW:0]           sig
);
  localparam int SRC_BIAS = 2**(EW-1) - 1;

  logic [EW-1:0] e_fld;
  logic [FW-1:0] f_fld;

  always_comb begin
    sign    = operand[EW+FW];
    e_fld   = operand[EW+FW-1:FW];
    f_fld   = operand[FW-1:0];
    sig     = {1'b1, f_fld};
    unb_exp = $signed({2'b00, e_fld}) - $signed((EW+2)'(SRC_BIAS));
    if (e_fld == '0)      cls = CL_ZERO;
    else if (e_fld == '1) cls = (f_fld == '0) ? CL_INF : CL_NAN;
    else                  cls = CL_NORM;
  end
endmodule

// File: rtl/tfp_round.sv
module tfp_round
  import tfp_pkg::*;
#(
  parameter int SW = 24,
  parameter int WW = 5
) (
  input  logic [SW-1:0] sig,
  input  logic [WW-1:0] sig_w,
  input  rmode_e        mode,
  output logic [SW:0]   kept_r,
  output logic          carry,
  output logic          inexact
);
  logic [SW-1:0] low_mask, half, disc, kept;
  logic [WW-1:0] shift;
  logic          inc, above, tie;

  always_comb begin
    shift    = WW'(SW) - sig_w;
    low_mask = {SW{1'b1}} >> sig_w;
    half     = low_mask ^ (low_mask >> 1);
    disc     = sig & low_mask;
    kept     = sig >> shift;
    inexact  = |disc;
    above    = disc > half;
    tie      = (disc == half) && (half != '0);
    case (mode)
      RM_HALF_UP:   inc = above | tie;
      RM_HALF_EVEN: inc = above | (tie & kept[0]);
      default:      inc = 1'b0;
    endcase
    if (mode == RM_ODD)
      kept_r = {1'b0, kept | {{(SW-1){1'b0}}, inexact}};
    else
      kept_r = {1'b0, kept} + {{SW{1'b0}}, inc};
    carry = |(kept_r >> sig_w);
  end

  // R8: a carry means the rounded significand reached exactly 2^m
  always_comb begin
    if (carry && sig_w != '0)
      assert (((kept_r >> sig_w) == (SW+1)'(1)) && ((kept_r & ({(SW+1){1'b1}} >> (WW'(SW+1) - sig_w))) == '0))
        else $error("p_carry_clean_r8");
  end
endmodule

// File: rtl/tfp_pack.sv
module tfp_pack
  import tfp_pkg::*;
#(
  parameter int SW = 24,
  parameter int WW = 5,
  parameter int XW = 4,
  parameter int BW = 8,
  parameter int UW = 10,
  parameter int OW = 32
) (
  input  logic                 sign,
  input  fclass_e              cls,
  input  logic signed [UW-1:0] unb_exp,
  input  logic [SW:0]          kept_r,
  input  logic                 carry,
  input  logic                 rnd_inexact,
  input  logic [WW-1:0]        sig_w,
  input  logic [XW-1:0]        exp_w,
  input  logic [BW-1:0]        bias,
  input  rmode_e               mode,
  output logic [OW-1:0]        word,
  output logic                 ovf,
  output logic                 unf,
  output logic                 inx
);
  localparam int TW = UW + 2;

  logic signed [TW-1:0] target;
  logic [TW-1:0]        exp_all, exp_top, exp_f;
  logic [OW-1:0]        frac_mask, frac_val, frac_f;
  logic [5:0]           fpos, spos;
  logic                 saturate;

  always_comb begin
    target    = TW'(unb_exp) + $signed({{(TW-BW){1'b0}}, bias})
              + $signed({{(TW-1){1'b0}}, carry});
    exp_all   = (TW'(1) << exp_w) - TW'(1);
    exp_top   = exp_all - TW'(1);
    frac_mask = (OW'(1) << (sig_w - WW'(1))) - OW'(1);
    frac_val  = OW'(kept_r) & frac_mask;
    fpos      = 6'(sig_w) - 6'd1;
    spos      = fpos + 6'(exp_w);
    saturate  = (mode == RM_TRUNC) || (mode == RM_ODD);
    exp_f  = '0;
    frac_f = '0;
    ovf    = 1'b0;
    unf    = 1'b0;
    inx    = 1'b0;
    case (cls)
      CL_INF: exp_f = exp_all;
      CL_NAN: begin
        exp_f  = exp_all;
        frac_f = OW'(1) << (sig_w - WW'(2));
      end
      CL_NORM: begin
        if (target > $signed(exp_top)) begin
          ovf = 1'b1;
          inx = 1'b1;
          if (saturate) begin
            exp_f  = exp_top;
            frac_f = frac_mask;
          end else begin
            exp_f = exp_all;
          end
        end else if (target < 1) begin
          unf = 1'b1;
          inx = 1'b1;
        end else begin
          exp_f  = target;
          frac_f = frac_val;
          inx    = rnd_inexact;
        end
      end
      default: ;
    endcase
    word = (OW'(sign) << spos) | (OW'(exp_f) << fpos) | frac_f;
  end

  // R10/R11: range exceptions are mutually exclusive and always inexact
  always_comb begin
    assert (!(ovf && unf)) else $error("p_range_excl_r10");
    if (ovf || unf) assert (inx) else $error("p_range_inexact_r11");
  end
endmodule

// File: rtl/tfp_rounder.sv
module tfp_rounder
  import tfp_pkg::*;
#(
  parameter int SRC_EW = 8,
  parameter int SRC_FW = 23,
  localparam int SW = SRC_FW + 1,
  localparam int WW = $clog2(SW + 1),
  localparam int XW = $clog2(SRC_EW + 1),
  localparam int BW = SRC_EW,
  localparam int UW = SRC_EW + 2,
  localparam int OW = SRC_EW + SRC_FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] op_i,
  input  logic [WW-1:0] sig_w_i,
  input  logic [XW-1:0] exp_w_i,
  input  logic [BW-1:0] bias_i,
  input  logic [1:0]    mode_i,
  output logic [OW-1:0] res_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          inx_o
);
  localparam int FULL_BIAS = 2**(SRC_EW-1) - 1;

  logic                 u_sign;
  fclass_e              u_cls;
  logic signed [UW-1:0] u_exp;
  logic [SW-1:0]        u_sig;
  logic [SW:0]          r_kept;
  logic                 r_carry, r_inx;
  logic [OW-1:0]        p_word;
  logic                 p_ovf, p_unf, p_inx;
  rmode_e               mode;

  assign mode = rmode_e'(mode_i);

  tfp_unpack #(.EW(SRC_EW), .FW(SRC_FW)) u_unpack (
    .operand(op_i), .sign(u_sign), .cls(u_cls), .unb_exp(u_exp), .sig(u_sig)
  );

  tfp_round #(.SW(SW), .WW(WW)) u_round (
    .sig(u_sig), .sig_w(sig_w_i), .mode(mode),
    .kept_r(r_kept), .carry(r_carry), .inexact(r_inx)
  );

  tfp_pack #(.SW(SW), .WW(WW), .XW(XW), .BW(BW), .UW(UW), .OW(OW)) u_pack (
    .sign(u_sign), .cls(u_cls), .unb_exp(u_exp), .kept_r(r_kept),
    .carry(r_carry), .rnd_inexact(r_inx), .sig_w(sig_w_i), .exp_w(exp_w_i),
    .bias(bias_i), .mode(mode), .word(p_word), .ovf(p_ovf), .unf(p_unf),
    .inx(p_inx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      inx_o <= 1'b0;
    end else begin
      res_o <= p_word;
      ovf_o <= p_ovf;
      unf_o <= p_unf;
      inx_o <= p_inx;
    end
  end

  p_layout_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((res_o >> (6'($past(sig_w_i)) + 6'($past(exp_w_i)))) == '0));

  p_identity_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sig_w_i) == WW'(SW) && $past(exp_w_i) == XW'(SRC_EW)
     && $past(bias_i) == BW'(FULL_BIAS)
     && $past(op_i[OW-2 -: SRC_EW]) != '0 && $past(op_i[OW-2 -: SRC_EW]) != '1)
    |-> (res_o == $past(op_i)));

  p_ovf_inexact_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (inx_o && !unf_o));

  p_unf_zero_r11: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (inx_o && $countones(res_o) <= 1));

  p_nan_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i[OW-2 -: SRC_EW]) == '1 && $past(op_i[SRC_FW-1:0]) != '0)
    |-> (!ovf_o && !unf_o && !inx_o && res_o != '0));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && !ovf_o && !unf_o && !inx_o));
endmodule

// File: tb/tfp_rounder_test.sv
module tfp_rounder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_i = '0;
  logic [4:0]  sig_w_i = 5'd24;
  logic [3:0]  exp_w_i = 4'd8;
  logic [7:0]  bias_i = 8'd127;
  logic [1:0]  mode_i = 2'd0;
  logic [31:0] res_o;
  logic        ovf_o, unf_o, inx_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tfp_rounder uut (
    .clk(clk), .rst(rst), .op_i(op_i), .sig_w_i(sig_w_i), .exp_w_i(exp_w_i),
    .bias_i(bias_i), .mode_i(mode_i), .res_o(res_o), .ovf_o(ovf_o),
    .unf_o(unf_o), .inx_o(inx_o)
  );

  typedef struct packed {
    logic [31:0] op;
    logic [4:0]  m;
    logic [3:0]  e;
    logic [7:0]  b;
    logic [1:0]  md;
    logic [31:0] res;
    logic [2:0]  fl;   // {ovf, unf, inx}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{32'h3FC00001, 5'd24, 4'd8, 8'd127, 2'd2, 32'h3FC00001, 3'b000, 4'd2},  // R2
    '{32'hFF800000, 5'd24, 4'd8, 8'd127, 2'd0, 32'hFF800000, 3'b000, 4'd2},  // R2
    '{32'hC0000000, 5'd8,  4'd8, 8'd127, 2'd2, 32'h0000C000, 3'b000, 4'd2},  // R2
    '{32'h3F800000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00003C00, 3'b000, 4'd2},  // R2
    '{32'h3F801000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00003C00, 3'b001, 4'd4},  // R4
    '{32'h3F801000, 5'd11, 4'd5, 8'd15,  2'd1, 32'h00003C01, 3'b001, 4'd5},  // R5
    '{32'h3F801000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00003C00, 3'b001, 4'd6},  // R6
    '{32'h3F801000, 5'd11, 4'd5, 8'd15,  2'd3, 32'h00003C01, 3'b001, 4'd7},  // R7
    '{32'h3F803000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00003C01, 3'b001, 4'd4},  // R4
    '{32'h3F803000, 5'd11, 4'd5, 8'd15,  2'd1, 32'h00003C02, 3'b001, 4'd5},  // R5
    '{32'h3F803000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00003C02, 3'b001, 4'd6},  // R6
    '{32'h3F803000, 5'd11, 4'd5, 8'd15,  2'd3, 32'h00003C01, 3'b001, 4'd7},  // R7
    '{32'h3F800FFF, 5'd11, 4'd5, 8'd15,  2'd1, 32'h00003C00, 3'b001, 4'd5},  // R5
    '{32'h3F800FFF, 5'd11, 4'd5, 8'd15,  2'd3, 32'h00003C01, 3'b001, 4'd7},  // R7
    '{32'h3F801001, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00003C01, 3'b001, 4'd6},  // R6
    '{32'h3FFFFFFF, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00004000, 3'b001, 4'd8},  // R8
    '{32'h3FFFFFFF, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00003FFF, 3'b001, 4'd4},  // R4
    '{32'h47C35000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00007C00, 3'b101, 4'd10}, // R10
    '{32'h47C35000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00007BFF, 3'b101, 4'd10}, // R10
    '{32'hC7C35000, 5'd11, 4'd5, 8'd15,  2'd3, 32'h0000FBFF, 3'b101, 4'd10}, // R10
    '{32'hC7C35000, 5'd11, 4'd5, 8'd15,  2'd1, 32'h0000FC00, 3'b101, 4'd10}, // R10
    '{32'h477FF000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00007C00, 3'b101, 4'd10}, // R10 carry
    '{32'h477FF000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00007BFF, 3'b001, 4'd8},  // R8
    '{32'h35800000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00000000, 3'b011, 4'd11}, // R11
    '{32'hB5800000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00008000, 3'b011, 4'd11}, // R11
    '{32'h00000001, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00000000, 3'b000, 4'd11}, // R11
    '{32'h38800000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00000400, 3'b000, 4'd11}, // R11
    '{32'h80000000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h00008000, 3'b000, 4'd11}, // R11
    '{32'h7F800001, 5'd11, 4'd5, 8'd15,  2'd2, 32'h00007E00, 3'b000, 4'd12}, // R12
    '{32'hFFC00000, 5'd11, 4'd5, 8'd15,  2'd0, 32'h0000FE00, 3'b000, 4'd12}, // R12
    '{32'hFF800000, 5'd11, 4'd5, 8'd15,  2'd2, 32'h0000FC00, 3'b000, 4'd12}, // R12
    '{32'h3F800000, 5'd11, 4'd5, 8'd20,  2'd2, 32'h00005000, 3'b000, 4'd9},  // R9
    '{32'h36800000, 5'd11, 4'd5, 8'd20,  2'd2, 32'h00000800, 3'b000, 4'd9},  // R9
    '{32'hBFC00000, 5'd3,  4'd5, 8'd15,  2'd2, 32'h000000BE, 3'b000, 4'd3},  // R3
    '{32'h3F800001, 5'd3,  4'd5, 8'd15,  2'd3, 32'h0000003D, 3'b001, 4'd7},  // R7
    '{32'h3F800000, 5'd7,  4'd6, 8'd31,  2'd2, 32'h000007C0, 3'b000, 4'd3},  // R3
    '{32'h3F802000, 5'd11, 4'd5, 8'd15,  2'd3, 32'h00003C01, 3'b000, 4'd13}  // R13
  };

  task automatic check(input int req, input logic [31:0] got_r, input logic [31:0] exp_r,
                       input logic [2:0] got_f, input logic [2:0] exp_f);
    n_cmp++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      n_bad++;
      $display("FAIL R%0d: res=%h flags=%b, expected res=%h flags=%b",
               req, got_r, got_f, exp_r, exp_f);
    end
  endtask

  task automatic drive(input vec_t v);
    op_i    = v.op;
    sig_w_i = v.m;
    exp_w_i = v.e;
    bias_i  = v.b;
    mode_i  = v.md;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    op_i = 32'h3F800000;
    repeat (3) @(negedge clk);
    check(1, res_o, 32'h0, {ovf_o, unf_o, inx_o}, 3'b000);
    rst = 1'b0;

    // Table walk: drive at a falling edge, sample one falling edge later
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(int'(VEC[i].req), res_o, VEC[i].res, {ovf_o, unf_o, inx_o}, VEC[i].fl);
    end

    // R1: one-cycle latency, no change before the edge
    drive(VEC[17]);
    @(negedge clk);
    drive(VEC[3]);
    #1;
    check(1, res_o, 32'h00007C00, {ovf_o, unf_o, inx_o}, 3'b101);
    @(negedge clk);
    check(1, res_o, 32'h00003C00, {ovf_o, unf_o, inx_o}, 3'b000);

    // R1: reset in mid-run clears result and flags
    drive(VEC[17]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(1, res_o, 32'h0, {ovf_o, unf_o, inx_o}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    check(10, res_o, 32'h00007C00, {ovf_o, unf_o, inx_o}, 3'b101);

    finish_run();
  end
endmodule